// File: doc/BRIEF.md
# Arithmetic Flag and Branch Condition Unit

This unit is the add/subtract core of a small processor datapath. From a destination operand, a source operand, an operand size, an operation code and the incoming carry, it produces the result at the selected width, together with the negative, zero, overflow and carry flags. It also produces a store enable that tells the register file whether to write the result, the flags packed into a condition byte, and a branch-taken bit for a selected condition, evaluated on the flags this operation produces.

Operations are add, add with carry, subtract, subtract with borrow, compare, negate, increment and decrement. The widths are 8, 16 and 32 bits. Each operation has its own carry rule: increment and decrement keep the incoming carry, negate reports a carry for any nonzero operand, and compare sets the flags without asking for a store. All outputs are registered and appear one clock after a valid request. They hold their values until the next request.

Top module: `arith_flag_unit`

## Requirements
- R1: All outputs are registered. A request presented with `in_valid` high at a rising edge shows its results after that edge, with `out_valid` high for that one cycle. While reset is low, every output is 0.
- R2: The `op` encodings are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 negate, 6 increment and 7 decrement. The `size` encodings are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. `result` is zero above the selected width, whatever the upper operand bits hold.
- R3: `flag_n` is the top bit of the result at the selected width. `flag_z` is 1 exactly when the result at that width is zero.
- R4: Add computes dst+src, and add with carry also adds `carry_in`. `flag_c` is the carry out of the selected width. `flag_v` is set when dst and src have the same sign and the result's sign differs from it.
- R5: Subtract computes dst-src, and subtract with borrow also subtracts `carry_in`. `flag_c` is the unsigned borrow. `flag_v` is set when dst and src have different signs and the result's sign differs from dst's sign.
- R6: Compare produces the subtract flags and the difference on `result`, but drives `store_en` low. Every other operation drives `store_en` high.
- R7: Negate computes 0-dst. `flag_c` is 1 when dst is nonzero at the selected width. `flag_v` is 1 only when dst is the most negative value of that width.
- R8: Increment and decrement change dst by 2 when src bit 1 is set, and by 1 otherwise. `flag_v` is the signed overflow of that step (for a step of 1: dst largest positive on increment, most negative on decrement). `flag_c` is copied from `carry_in`.
- R9: `ccr_out` carries N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. Bits 7 to 4 are zero.
- R10: `taken` evaluates `cond` on the new flags: 0 always, 1 never, 2 !(C|Z), 3 C|Z, 4 !C, 5 C, 6 !Z, 7 Z, 8 !V, 9 V, 10 !N, 11 N, 12 !(N^V), 13 N^V, 14 (greater) Z|(N^V)==0, 15 (less-or-equal) Z|(N^V)==1.
- R11: While `in_valid` is low, `result`, the flags, `store_en`, `ccr_out` and `taken` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| size | input | 2 | Operand width select |
| dst | input | 32 | Destination operand |
| src | input | 32 | Source operand; bit 1 selects the step for increment/decrement |
| carry_in | input | 1 | Current carry flag |
| cond | input | 4 | Branch condition selector |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Result, zero-extended from the selected width |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |
| store_en | output | 1 | Result should be written back |
| ccr_out | output | 8 | Packed condition byte |
| taken | output | 1 | Selected branch condition holds |

## Verification
Every result of this unit is due exactly one rising edge after the request that caused it, and all of them appear in the same cycle. No result reaches the outputs on a later edge. The bench drives each request on a falling edge and samples one nanosecond after the next rising edge, so each comparison sees exactly that request's outputs. For the hold requirement, the bench changes the inputs with `in_valid` low and samples two edges later, so that any wrongly captured value would already be visible.

// File: rtl/arith_flag_unit.sv
module arith_flag_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic [31:0] dst,
  input  logic [31:0] src,
  input  logic        carry_in,
  input  logic [3:0]  cond,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c,
  output logic        store_en,
  output logic [7:0]  ccr_out,
  output logic        taken
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADDC = 3'd1, OP_SUB = 3'd2, OP_SUBB = 3'd3,
                         OP_CMP = 3'd4, OP_NEG = 3'd5, OP_INC = 3'd6, OP_DEC = 3'd7;

  logic [31:0] opa, opb, bb, res;
  logic        cin, is_sub, ci, co, sa, sbb, sr;
  logic        n_nx, z_nx, v_nx, c_nx, tk_nx;
  logic [8:0]  s8;
  logic [16:0] s16;
  logic [32:0] s32;

  always_comb begin
    opa = dst;
    opb = src;
    cin = 1'b0;
    is_sub = 1'b0;
    case (op)
      OP_ADD:  ;
      OP_ADDC: cin = carry_in;
      OP_SUB, OP_CMP: is_sub = 1'b1;
      OP_SUBB: begin is_sub = 1'b1; cin = carry_in; end
      OP_NEG:  begin opa = 32'd0; opb = dst; is_sub = 1'b1; end
      OP_INC:  opb = src[1] ? 32'd2 : 32'd1;
      OP_DEC:  begin opb = src[1] ? 32'd2 : 32'd1; is_sub = 1'b1; end
      default: ;
    endcase
  end

  assign bb  = is_sub ? ~opb : opb;
  assign ci  = is_sub ? ~cin : cin;
  assign s8  = {1'b0, opa[7:0]}  + {1'b0, bb[7:0]}  + {8'd0, ci};
  assign s16 = {1'b0, opa[15:0]} + {1'b0, bb[15:0]} + {16'd0, ci};
  assign s32 = {1'b0, opa}       + {1'b0, bb}       + {32'd0, ci};

  always_comb begin
    case (size)
      2'd0: begin
        res = {24'd0, s8[7:0]};   co = s8[8];
        sa = opa[7];  sbb = bb[7];  sr = s8[7];
      end
      2'd1: begin
        res = {16'd0, s16[15:0]}; co = s16[16];
        sa = opa[15]; sbb = bb[15]; sr = s16[15];
      end
      default: begin
        res = s32[31:0];          co = s32[32];
        sa = opa[31]; sbb = bb[31]; sr = s32[31];
      end
    endcase
  end

  assign n_nx = sr;
  assign z_nx = (res == 32'd0);
  assign v_nx = (sa == sbb) && (sr != sa);
  assign c_nx = (op == OP_INC || op == OP_DEC) ? carry_in : (is_sub ? ~co : co);

  always_comb begin
    case (cond)
      4'd0:  tk_nx = 1'b1;
      4'd1:  tk_nx = 1'b0;
      4'd2:  tk_nx = !(c_nx | z_nx);
      4'd3:  tk_nx = c_nx | z_nx;
      4'd4:  tk_nx = !c_nx;
      4'd5:  tk_nx = c_nx;
      4'd6:  tk_nx = !z_nx;
      4'd7:  tk_nx = z_nx;
      4'd8:  tk_nx = !v_nx;
      4'd9:  tk_nx = v_nx;
      4'd10: tk_nx = !n_nx;
      4'd11: tk_nx = n_nx;
      4'd12: tk_nx = !(n_nx ^ v_nx);
      4'd13: tk_nx = n_nx ^ v_nx;
      4'd14: tk_nx = !(z_nx | (n_nx ^ v_nx));
      default: tk_nx = z_nx | (n_nx ^ v_nx);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 32'd0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      store_en  <= 1'b0;
      taken     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= res;
        flag_n   <= n_nx;
        flag_z   <= z_nx;
        flag_v   <= v_nx;
        flag_c   <= c_nx;
        store_en <= (op != OP_CMP);
        taken    <= tk_nx;
      end
    end
  end

  assign ccr_out = {4'd0, flag_n, flag_z, flag_v, flag_c};
endmodule

module arith_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [1:0]  size,
  input logic [31:0] dst,
  input logic        carry_in,
  input logic [3:0]  cond,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_v,
  input logic        flag_c,
  input logic        store_en,
  input logic        taken
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_byte_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd0) |=> (result[31:8] == 24'd0));
  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (result == 32'd0)));
  assert_cmp_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4) |=> !store_en);
  assert_neg_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5 && size[1] && dst == 32'h8000_0000) |=> (flag_v && flag_c));
  assert_step_keeps_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 3'd6 || op == 3'd7)) |=> (flag_c == $past(carry_in)));
  assert_greater_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 4'd14) |=> (taken == !(flag_z | (flag_n ^ flag_v))));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(taken) && $stable(store_en)));
endmodule

bind arith_flag_unit arith_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size), .dst(dst),
  .carry_in(carry_in), .cond(cond), .out_valid(out_valid), .result(result),
  .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
  .store_en(store_en), .taken(taken)
);

// File: tb/arith_flag_unit_tb.sv
`timescale 1ns/1ps
module arith_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [1:0]  size = 2'd0;
  logic [31:0] dst = 32'd0, src = 32'd0;
  logic        carry_in = 1'b0;
  logic [3:0]  cond = 4'd0;
  logic        out_valid, flag_n, flag_z, flag_v, flag_c, store_en, taken;
  logic [31:0] result;
  logic [7:0]  ccr_out;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  arith_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .dst(dst), .src(src), .carry_in(carry_in), .cond(cond),
    .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .store_en(store_en), .ccr_out(ccr_out),
    .taken(taken)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (op %0d size %0d dst %0h src %0h)",
               req, act, exp, op, size, dst, src);
    end
  endtask

  function automatic longint sx(input longint x, input int w);
    return ((x >> (w - 1)) & 1) != 0 ? x - (longint'(1) << w) : x;
  endfunction

  function automatic void model(input int o, input int sz, input longint d, input longint s,
                                input bit ci, input int cd, output longint r, output bit n,
                                output bit z, output bit v, output bit c, output bit st,
                                output bit tk);
    int w;
    longint m, a, b, smax, smin, sres, k;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    a = d & m;
    b = s & m;
    k = ((s >> 1) & 1) != 0 ? 2 : 1;
    case (o)
      0, 1: begin
        r = a + b + ((o == 1) ? longint'(ci) : 0);
        c = ((r >> w) & 1) != 0;
        sres = sx(a, w) + sx(b, w) + ((o == 1) ? longint'(ci) : 0);
      end
      2, 3, 4: begin
        r = a - b - ((o == 3) ? longint'(ci) : 0);
        c = a < b + ((o == 3) ? longint'(ci) : 0);
        sres = sx(a, w) - sx(b, w) - ((o == 3) ? longint'(ci) : 0);
      end
      5: begin
        r = -a;
        c = (a != 0);
        sres = -sx(a, w);
      end
      6: begin r = a + k; c = ci; sres = sx(a, w) + k; end
      default: begin r = a - k; c = ci; sres = sx(a, w) - k; end
    endcase
    r = r & m;
    v = (sres > smax) || (sres < smin);
    n = ((r >> (w - 1)) & 1) != 0;
    z = (r == 0);
    st = (o != 4);
    case (cd)
      0: tk = 1; 1: tk = 0; 2: tk = !(c | z); 3: tk = c | z;
      4: tk = !c; 5: tk = c; 6: tk = !z; 7: tk = z;
      8: tk = !v; 9: tk = v; 10: tk = !n; 11: tk = n;
      12: tk = !(n ^ v); 13: tk = n ^ v; 14: tk = !(z | (n ^ v));
      default: tk = z | (n ^ v);
    endcase
  endfunction

  task automatic run(input int o, input int sz, input logic [31:0] d, input logic [31:0] s,
                     input bit ci, input int cd);
    longint er;
    bit en, ez, ev, ec, est, etk;
    op = 3'(o); size = 2'(sz); dst = d; src = s; carry_in = ci; cond = 4'(cd);
    in_valid = 1'b1;
    model(o, sz, longint'(d), longint'(s), ci, cd, er, en, ez, ev, ec, est, etk);
    @(posedge clk); #1;
    chk(out_valid == 1'b1, "R1 out_valid", out_valid, 1);
    chk(result == 32'(er), (o < 2) ? "R4 R2 result" : (o < 5) ? "R5 R2 result" :
        (o == 5) ? "R7 R2 result" : "R8 R2 result", result, er);
    chk(ccr_out == {4'd0, en, ez, ev, ec},
        (o < 2) ? "R4 R3 R9 flags" : (o < 5) ? "R5 R3 R9 flags" :
        (o == 5) ? "R7 R3 R9 flags" : "R8 R3 R9 flags", ccr_out, {4'd0, en, ez, ev, ec});
    chk(store_en == est, "R6 store_en", store_en, est);
    chk(taken == etk, "R10 taken", taken, etk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [31:0] blist8 [12] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h7f, 32'h80, 32'h81, 32'hfe,
                               32'hff, 32'h40, 32'h55, 32'haa};
  logic [31:0] blist16 [8] = '{32'h0, 32'h1, 32'h2, 32'h7fff, 32'h8000, 32'h8001, 32'hfffe, 32'hffff};
  logic [31:0] blist32 [8] = '{32'h0, 32'h1, 32'h2, 32'h7fff_ffff, 32'h8000_0000,
                               32'h8000_0001, 32'hffff_fffe, 32'hffff_ffff};

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result == 32'd0 && ccr_out == 8'd0 && !out_valid && !store_en && !taken,
        "R1 reset state", {ccr_out, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 0; o < 8; o++)
      for (int d = 0; d < 256; d++)
        for (int j = 0; j < 12; j++)
          run(o, 0, {24'hA5C3E1, 8'(d)}, 32'h3C5A_9600 | blist8[j],
              bit'(d[0] ^ j[0]), (d + j + o) % 16);

    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          run(o, 1, 32'hBEEF_0000 | blist16[i], 32'h1234_0000 | blist16[j],
              bit'(i[0] ^ j[1]), (i * 8 + j + o) % 16);
          run(o, (i + j) % 2 == 0 ? 2 : 3, blist32[i], blist32[j],
              bit'(i[1] ^ j[0]), (i * 3 + j + o) % 16);
        end

    run(4, 2, 32'h7fff_ffff, 32'hffff_ffff, 1'b0, 14);
    run(5, 2, 32'h8000_0000, 32'h0, 1'b0, 9);
    run(7, 2, 32'h8000_0001, 32'h2, 1'b1, 15);
    run(6, 0, 32'h7e, 32'h2, 1'b0, 9);

    run(0, 1, 32'h0000_7fff, 32'h1, 1'b0, 11);
    op = 3'd2; size = 2'd0; dst = 32'h55; src = 32'hAA; carry_in = 1'b1; cond = 4'd1;
    repeat (2) @(negedge clk);
    chk(result == 32'h8000, "R11 hold result", result, 32'h8000);
    chk(ccr_out == 8'b0000_1010, "R11 hold flags", ccr_out, 8'b0000_1010);
    chk(!out_valid && store_en && taken, "R11 hold strobe/store/taken",
        {out_valid, store_en, taken}, 3'b011);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule